// File: doc/BRIEF.md
# One-Hot Tally Network

This block counts how many bits of an N-bit input word are set and reports the result on N+1 output lines. Exactly one of these lines is high, and the position of that line is the count. Line 0 means no bit is set and line N means every bit is set. The same count is also given as a plain binary number. The block is purely combinational.

Internally a single token travels through a chain of identical stages, one stage for each input bit. The chain starts with the token on line 0. A stage whose input bit is 0 passes the token through unchanged. A stage whose input bit is 1 moves it up by one line. Every line that a stage does not feed from the previous stage is tied to 0, so no output is ever undriven. A one-hot-to-binary encoder then produces the binary count from the final vector.

Top module: `tally_net`

## Requirements
- R1: For every input pattern, exactly one bit of `tally_o` is 1.
- R2: The set bit of `tally_o` is at index p, where p is the number of 1 bits in `bits_i`.
- R3: An all-zero input gives `tally_o` equal to 1 (only line 0 high).
- R4: An all-ones input gives only line N high (`tally_o` equal to 1<<N).
- R5: The result depends only on how many bits are set, not on their positions. Two inputs with the same number of set bits give identical outputs.
- R6: `count_o` is an unsigned binary number of $clog2(N+1) bits. It equals the index of the set bit of `tally_o`.
- R7: Changing any single input bit from 0 to 1, with all other bits held, moves the set line of `tally_o` up by exactly one position.
- R8: With N=2 the results are: input 00 gives line 0, input 01 or 10 gives line 1, and input 11 gives line 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bits_i | input | N | Bits to be counted |
| tally_o | output | N+1 | One-hot count; bit k high means k input bits are set |
| count_o | output | $clog2(N+1) | Binary count |

## Verification
The bench builds three instances of the block. The instance with the default N=8 is small enough to drive through all 256 input patterns. It is also used for the single-bit toggle checks and for the order-independence checks. A second instance with N=2 covers the four-row truth table exactly. A third instance with N=13 gets seeded random patterns; this width leaves the top code of the 4-bit binary count unused and forces the chain's zero-filled upper lines to hold in a wider network.

// File: rtl/tally_pkg.sv
package tally_pkg;
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tally_stage.sv
// One cascade step: pass the token straight through, or move it up one line.
module tally_stage #(
  parameter int IN_W = 1
) (
  input  logic            bit_i,
  input  logic [IN_W-1:0] vec_i,
  output logic [IN_W:0]   vec_o
);
  always_comb begin
    if (bit_i) vec_o = {vec_i, 1'b0};
    else       vec_o = {1'b0, vec_i};
  end
endmodule

// File: rtl/tally_chain.sv
module tally_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits_i,
  output logic [N:0]   tally_o
);
  logic [N:0] vec [N+1];

  // seed token on line 0
  assign vec[0] = {{N{1'b0}}, 1'b1};

  for (genvar k = 0; k < N; k++) begin : g_stage
    tally_stage #(.IN_W(k + 1)) u_stage (
      .bit_i (bits_i[k]),
      .vec_i (vec[k][k:0]),
      .vec_o (vec[k+1][k+1:0])
    );
    if (k + 2 <= N) begin : g_fill
      assign vec[k+1][N:k+2] = '0;
    end
  end

  assign tally_o = vec[N];
endmodule

// File: rtl/tally_encoder.sv
module tally_encoder #(
  parameter int N  = 8,
  parameter int CW = tally_pkg::cnt_w(N)
) (
  input  logic [N:0]    onehot_i,
  output logic [CW-1:0] bin_o
);
  for (genvar b = 0; b < CW; b++) begin : g_bit
    always_comb begin
      bin_o[b] = 1'b0;
      for (int j = 0; j <= N; j++) begin
        if (((j >> b) & 1) == 1) bin_o[b] = bin_o[b] | onehot_i[j];
      end
    end
  end
endmodule

// File: rtl/tally_net.sv
module tally_net #(
  parameter int N = 8,
  localparam int CW = tally_pkg::cnt_w(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic [N:0]    tally_o,
  output logic [CW-1:0] count_o
);
  tally_chain #(.N(N)) u_chain (
    .bits_i  (bits_i),
    .tally_o (tally_o)
  );

  tally_encoder #(.N(N), .CW(CW)) u_enc (
    .onehot_i (tally_o),
    .bin_o    (count_o)
  );
endmodule

// File: rtl/tally_net_chk.sv
module tally_net_chk #(
  parameter int N = 8,
  localparam int CW = tally_pkg::cnt_w(N)
) (
  input logic [N-1:0]  bits_i,
  input logic [N:0]    tally_i,
  input logic [CW-1:0] count_i
);
  always_comb begin
    if (!$isunknown(bits_i)) begin
      assert_onehot_R1: assert ($onehot(tally_i));
      assert_pop_line_R2: assert (((tally_i >> $countones(bits_i)) & 1) != 0);
      assert_bin_match_R6: assert (((tally_i >> count_i) & 1) != 0);
      if (bits_i == '0) begin
        assert_zero_in_R3: assert (tally_i[0]);
      end
      if (&bits_i) begin
        assert_full_in_R4: assert (tally_i[N]);
      end
    end
  end
endmodule

bind tally_net tally_net_chk #(.N(N)) u_chk (
  .bits_i  (bits_i),
  .tally_i (tally_o),
  .count_i (count_o)
);

// File: tb/tally_net_tb.sv
module tally_net_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  b8  = '0;
  logic [1:0]  b2  = '0;
  logic [12:0] b13 = '0;
  logic [8:0]  t8;
  logic [3:0]  c8;
  logic [2:0]  t2;
  logic [1:0]  c2;
  logic [13:0] t13;
  logic [3:0]  c13;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;

  tally_net #(.N(8))  u_dut      (.bits_i(b8),  .tally_o(t8),  .count_o(c8));
  tally_net #(.N(2))  u_dut_pair (.bits_i(b2),  .tally_o(t2),  .count_o(c2));
  tally_net #(.N(13)) u_dut_wide (.bits_i(b13), .tally_o(t13), .count_o(c13));

  function automatic int pop(input int v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  initial begin
    int s;
    int prev;
    void'($urandom(32'd20240611));
    step();
    // R3: zero input
    chk("R3 zero tally", int'(t8), 1);
    chk("R3 zero count", int'(c8), 0);
    // R4: all ones
    b8 = 8'hFF; b13 = 13'h1FFF; step();
    chk("R4 full tally N8", int'(t8), 1 << 8);
    chk("R4 full count N8", int'(c8), 8);
    chk("R4 full tally N13", int'(t13), 1 << 13);
    chk("R4 full count N13", int'(c13), 13);
    // R1 R2 R6: exhaustive N=8
    for (int v = 0; v < 256; v++) begin
      b8 = 8'(v); step();
      chk("R1 onehot", $countones(t8), 1);
      chk("R2 line", int'(t8), 1 << pop(v));
      chk("R6 count", int'(c8), pop(v));
    end
    // R8: N=2 truth table
    for (int v = 0; v < 4; v++) begin
      b2 = 2'(v); step();
      chk("R8 pair tally", int'(t2), (v == 0) ? 1 : (v == 3) ? 4 : 2);
      chk("R8 pair count", int'(c2), pop(v));
    end
    // R5: same popcount, different positions
    b8 = 8'b0000_0111; step(); s = int'(t8);
    b8 = 8'b1010_0010; step();
    chk("R5 order", int'(t8), s);
    b8 = 8'b1110_0000; step();
    chk("R5 order", int'(t8), s);
    b8 = 8'b0001_1000; step(); s = int'(t8);
    b8 = 8'b1000_0001; step();
    chk("R5 order", int'(t8), s);
    // R7: single 0->1 toggle
    for (int r = 0; r < 40; r++) begin
      int pos = int'($urandom_range(7, 0));
      int base = int'($urandom_range(255, 0)) & ~(1 << pos);
      b8 = 8'(base); step(); prev = int'(t8);
      b8 = 8'(base | (1 << pos)); step();
      chk("R7 toggle", int'(t8), prev << 1);
    end
    // R1 R2 R6: random N=13
    for (int r = 0; r < 400; r++) begin
      int v = int'($urandom_range(8191, 0));
      b13 = 13'(v); step();
      chk("R1 onehot N13", $countones(t13), 1);
      chk("R2 line N13", int'(t13), 1 << pop(v));
      chk("R6 count N13", int'(c13), pop(v));
    end
    finish_run();
  end
endmodule